// File: doc/BRIEF.md
# Deferred-Fault Register Poison Tracker

This block keeps one poison flag per architectural register, so that a fault from a speculatively executed instruction can be held back until its result is actually needed. It looks at each retiring instruction: its speculative or normal marking, up to two source register indices (each with its own valid bit), an optional destination write, and a fault flag from execution. From these it decides whether to tag the destination, carry an existing tag forward, clear a tag, or tell the pipeline to trap.

A speculative instruction never traps. If it faults, or if it reads a tagged register, its destination is tagged. A normal instruction that reads a tagged register traps. The block reports which register caused the trap, and the poison state does not change in that cycle. A normal instruction that writes cleanly removes the tag from its destination. The poison vector is a register. An update made by one instruction is seen by the instruction that follows it in the next cycle.

Top module: `poison_tracker`

## Requirements
- R1: A synchronous reset clears every poison bit and holds `trap_o` low.
- R2: A valid speculative instruction with `exc_flag` high and `dst_we` high sets the poison bit of `dst_idx` one cycle later. No other bit changes.
- R3: A valid speculative instruction whose valid source 0 or valid source 1 is poisoned, with `dst_we` high, sets the poison bit of `dst_idx`. The two source hits are ORed.
- R4: A valid speculative instruction with no poisoned valid source, `exc_flag` low and `dst_we` high clears the poison bit of `dst_idx`.
- R5: A valid normal instruction with a poisoned valid source raises `trap_o` one cycle later, with `trap_kind` = 1. `trap_reg` is the lowest-numbered poisoned source index, and no poison bit changes. This takes priority over `exc_flag`.
- R6: A valid normal instruction with `exc_flag` high and no poisoned valid source raises `trap_o` one cycle later, with `trap_kind` = 0 and `trap_reg` = 0. No poison bit changes.
- R7: A valid normal instruction with no poisoned valid source, `exc_flag` low and `dst_we` high clears the poison bit of `dst_idx`, and does not trap.
- R8: A speculative instruction never raises `trap_o`.
- R9: Nothing happens in these cases: a cycle with `instr_vld` low, a source whose valid bit is low, or a write with `dst_we` low. The poison vector is not changed and no trap is raised.
- R10: A poison update made by one instruction is seen by an instruction presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_vld | input | 1 | A retiring instruction is presented |
| instr_spec | input | 1 | 1 = speculative, 0 = normal |
| src0_vld | input | 1 | Source 0 is read |
| src0_idx | input | IDXW (5) | Source 0 register index |
| src1_vld | input | 1 | Source 1 is read |
| src1_idx | input | IDXW (5) | Source 1 register index |
| dst_we | input | 1 | Instruction writes a destination |
| dst_idx | input | IDXW (5) | Destination register index |
| exc_flag | input | 1 | Execution raised a fault for this instruction |
| poison_vec | output | NREG (32) | Current poison bit of every register |
| trap_o | output | 1 | Pipeline must take an exception (registered) |
| trap_kind | output | 1 | 1 = consumed poisoned source, 0 = own fault |
| trap_reg | output | IDXW (5) | Offending source register, 0 for own fault |

## Verification
A wrong poison bit does not show up when it is written. It appears only when a later normal instruction reads that register. At that point the trap either fires when it should not, or stays silent when it should fire. Because of this, the poison vector is compared at the ports after every instruction, in the cycle right after the update, and not only when traps occur. Source indices are often drawn from a small range, so that tags are written and then read back within a few instructions. This catches mistakes in propagation and clearing before they are masked by later writes.

// File: rtl/poison_pkg.sv
package poison_pkg;

  typedef enum logic {
    TRAP_OWN_FAULT = 1'b0,
    TRAP_POISON_SRC = 1'b1
  } trap_kind_e;

  typedef struct packed {
    logic       trap;
    trap_kind_e kind;
    logic       wr_en;
    logic       wr_val;
  } verdict_t;

endpackage

// File: rtl/poison_lookup.sv
module poison_lookup #(
  parameter int NREG = 32,
  parameter int NSRC = 2,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0]      vec_i,
  input  logic [NSRC-1:0]      src_vld_i,
  input  logic [NSRC*IDXW-1:0] src_idx_i,
  output logic [NSRC-1:0]      hit_o,
  output logic                 any_hit_o,
  output logic [IDXW-1:0]      low_idx_o
);

  for (genvar p = 0; p < NSRC; p++) begin : g_port
    assign hit_o[p] = src_vld_i[p] & vec_i[src_idx_i[p*IDXW +: IDXW]];
  end

  always_comb begin
    any_hit_o = 1'b0;
    low_idx_o = '0;
    for (int p = 0; p < NSRC; p++) begin
      if (hit_o[p] && (!any_hit_o || (src_idx_i[p*IDXW +: IDXW] < low_idx_o))) begin
        low_idx_o = src_idx_i[p*IDXW +: IDXW];
        any_hit_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/poison_decide.sv
module poison_decide
  import poison_pkg::*;
(
  input  logic     vld_i,
  input  logic     spec_i,
  input  logic     exc_i,
  input  logic     dst_we_i,
  input  logic     src_hit_i,
  output verdict_t verdict_o
);

  always_comb begin
    verdict_o = '{trap: 1'b0, kind: TRAP_OWN_FAULT, wr_en: 1'b0, wr_val: 1'b0};
    if (vld_i) begin
      if (spec_i) begin
        // deferred: tag on fault or tainted input, else clean write
        verdict_o.wr_en  = dst_we_i;
        verdict_o.wr_val = exc_i | src_hit_i;
      end else if (src_hit_i) begin
        verdict_o.trap = 1'b1;
        verdict_o.kind = TRAP_POISON_SRC;
      end else if (exc_i) begin
        verdict_o.trap = 1'b1;
        verdict_o.kind = TRAP_OWN_FAULT;
      end else begin
        verdict_o.wr_en  = dst_we_i;
        verdict_o.wr_val = 1'b0;
      end
    end
  end

endmodule

// File: rtl/poison_file.sv
module poison_file #(
  parameter int NREG = 32,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic            wr_val_i,
  output logic [NREG-1:0] vec_o
);

  for (genvar r = 0; r < NREG; r++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        vec_o[r] <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == IDXW'(r))) begin
        vec_o[r] <= wr_val_i;
      end
    end
  end

  AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (rst)
    $countones(vec_o ^ $past(vec_o)) <= 1);  // R2

  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(vec_o));  // R9

endmodule

// File: rtl/poison_tracker.sv
module poison_tracker
  import poison_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_vld,
  input  logic            instr_spec,
  input  logic            src0_vld,
  input  logic [IDXW-1:0] src0_idx,
  input  logic            src1_vld,
  input  logic [IDXW-1:0] src1_idx,
  input  logic            dst_we,
  input  logic [IDXW-1:0] dst_idx,
  input  logic            exc_flag,
  output logic [NREG-1:0] poison_vec,
  output logic            trap_o,
  output logic            trap_kind,
  output logic [IDXW-1:0] trap_reg
);

  logic [NSRC-1:0]      hit;
  logic                 any_hit;
  logic [IDXW-1:0]      low_idx;
  verdict_t             verdict;

  poison_lookup #(.NREG(NREG), .NSRC(NSRC)) lookup_i (
    .vec_i     (poison_vec),
    .src_vld_i ({src1_vld, src0_vld}),
    .src_idx_i ({src1_idx, src0_idx}),
    .hit_o     (hit),
    .any_hit_o (any_hit),
    .low_idx_o (low_idx)
  );

  poison_decide decide_i (
    .vld_i     (instr_vld),
    .spec_i    (instr_spec),
    .exc_i     (exc_flag),
    .dst_we_i  (dst_we),
    .src_hit_i (any_hit),
    .verdict_o (verdict)
  );

  poison_file #(.NREG(NREG)) file_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (verdict.wr_en),
    .wr_idx_i (dst_idx),
    .wr_val_i (verdict.wr_val),
    .vec_o    (poison_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o    <= 1'b0;
      trap_kind <= 1'b0;
      trap_reg  <= '0;
    end else begin
      trap_o    <= verdict.trap;
      trap_kind <= verdict.kind;
      trap_reg  <= (verdict.trap && verdict.kind == TRAP_POISON_SRC) ? low_idx : '0;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (poison_vec == '0) && !trap_o);  // R1

  AST_SPEC_NEVER_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (instr_vld && instr_spec) |=> !trap_o);  // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !instr_vld |=> !trap_o && $stable(poison_vec));  // R9

  AST_TRAP_FREEZES_STATE: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> poison_vec == $past(poison_vec));  // R5

  AST_TRAP_REG_POISONED: assert property (@(posedge clk) disable iff (rst)
    (trap_o && trap_kind) |-> poison_vec[trap_reg]);  // R5

  AST_OWN_FAULT_REG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (trap_o && !trap_kind) |-> trap_reg == '0);  // R6

endmodule

// File: tb/poison_tracker_tb_top.sv
module poison_tracker_tb_top;

  localparam int NREG = 32;
  localparam int IDXW = $clog2(NREG);

  logic            clk = 1'b0;
  logic            rst;
  logic            instr_vld, instr_spec, src0_vld, src1_vld, dst_we, exc_flag;
  logic [IDXW-1:0] src0_idx, src1_idx, dst_idx;
  logic [NREG-1:0] poison_vec;
  logic            trap_o, trap_kind;
  logic [IDXW-1:0] trap_reg;

  int n_cmp = 0;
  int n_bad = 0;
  logic [NREG-1:0] ref_vec;

  always #2.5 clk = ~clk;

  poison_tracker #(.NREG(NREG)) dut_i (
    .clk(clk), .rst(rst), .instr_vld(instr_vld), .instr_spec(instr_spec),
    .src0_vld(src0_vld), .src0_idx(src0_idx), .src1_vld(src1_vld), .src1_idx(src1_idx),
    .dst_we(dst_we), .dst_idx(dst_idx), .exc_flag(exc_flag),
    .poison_vec(poison_vec), .trap_o(trap_o), .trap_kind(trap_kind), .trap_reg(trap_reg)
  );

  function automatic string tag_of(logic v, logic s, logic e, logic hit);
    if (!v) return "R9";
    if (s) return (e || hit) ? "R2/R3" : "R4";
    if (hit) return "R5";
    if (e) return "R6";
    return "R7";
  endfunction

  task automatic compare(string tag, logic et, logic ek, logic [IDXW-1:0] er, logic [NREG-1:0] ev);
    n_cmp++;
    if (trap_o !== et || (et && (trap_kind !== ek || trap_reg !== er)) || poison_vec !== ev) begin
      n_bad++;
      $display("FAIL %s: trap=%b kind=%b reg=%0d vec=%h expected trap=%b kind=%b reg=%0d vec=%h",
               tag, trap_o, trap_kind, trap_reg, poison_vec, et, ek, er, ev);
    end
  endtask

  // Apply one instruction, advance one edge, compare against the model.
  task automatic issue(logic v, logic s, logic s0v, logic [IDXW-1:0] s0, logic s1v,
                       logic [IDXW-1:0] s1, logic we, logic [IDXW-1:0] d, logic e, string force_tag);
    logic h0, h1, hit, et, ek;
    logic [IDXW-1:0] er;
    logic [NREG-1:0] nv;
    string t;
    instr_vld = v; instr_spec = s; src0_vld = s0v; src0_idx = s0;
    src1_vld = s1v; src1_idx = s1; dst_we = we; dst_idx = d; exc_flag = e;
    h0 = s0v && ref_vec[s0];
    h1 = s1v && ref_vec[s1];
    hit = h0 || h1;
    et = 1'b0; ek = 1'b0; er = '0; nv = ref_vec;
    if (v) begin
      if (s) begin
        if (we) nv[d] = e || hit;
      end else if (hit) begin
        et = 1'b1; ek = 1'b1;
        if (h0 && h1) er = (s0 < s1) ? s0 : s1;
        else er = h0 ? s0 : s1;
      end else if (e) begin
        et = 1'b1; ek = 1'b0;
      end else if (we) begin
        nv[d] = 1'b0;
      end
    end
    t = (force_tag != "") ? force_tag : tag_of(v, s, e, hit);
    @(posedge clk); #1;
    compare(t, et, ek, er, nv);
    ref_vec = nv;
  endtask

  initial begin
    #500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    instr_vld = 0; instr_spec = 0; src0_vld = 0; src1_vld = 0; dst_we = 0; exc_flag = 0;
    src0_idx = '0; src1_idx = '0; dst_idx = '0;
    repeat (3) @(posedge clk);
    #1;
    ref_vec = '0;
    compare("R1", 1'b0, 1'b0, '0, '0);
    rst = 1'b0;

    // R2: speculative fault tags destination
    issue(1, 1, 0, 0, 0, 0, 1, 5'd5, 1, "R2");
    // R3: propagation through source 1 (source 0 clean); R10 back-to-back use
    issue(1, 1, 1, 5'd1, 1, 5'd5, 1, 5'd7, 0, "R3/R10");
    // R3: propagation through source 0
    issue(1, 1, 1, 5'd7, 1, 5'd2, 1, 5'd12, 0, "R3");
    // R4: clean speculative write clears tag
    issue(1, 1, 1, 5'd0, 0, 0, 1, 5'd5, 0, "R4");
    // R9: invalid source pointing at a poisoned reg is ignored
    issue(1, 0, 0, 5'd7, 1, 5'd3, 1, 5'd20, 0, "R9");
    // R9: idle cycle with fault and write asserted does nothing
    issue(0, 1, 1, 5'd12, 0, 0, 1, 5'd8, 1, "R9");
    // R9: speculative fault without write leaves state
    issue(1, 1, 0, 0, 0, 0, 0, 5'd9, 1, "R9");
    // R5: both sources poisoned, lowest index reported, fault ignored
    issue(1, 0, 1, 5'd12, 1, 5'd7, 1, 5'd12, 1, "R5");
    // R5: only source 0 poisoned
    issue(1, 0, 1, 5'd12, 1, 5'd3, 1, 5'd7, 0, "R5");
    // R6: normal own fault, destination untouched
    issue(1, 0, 1, 5'd1, 0, 0, 1, 5'd7, 1, "R6");
    // R7: normal clean write clears tag
    issue(1, 0, 1, 5'd1, 1, 5'd2, 1, 5'd7, 0, "R7");
    // R8: speculative reading poison and faulting does not trap
    issue(1, 1, 1, 5'd12, 1, 5'd12, 1, 5'd31, 1, "R8");
    // R10: next instruction traps on the just-tagged register 31
    issue(1, 0, 1, 5'd31, 0, 0, 0, 0, 0, "R10");

    for (int n = 0; n < 3000; n++) begin
      logic [IDXW-1:0] a, b, d;
      logic narrow;
      narrow = ($urandom % 4) != 0;
      a = narrow ? IDXW'($urandom % 6) : IDXW'($urandom);
      b = narrow ? IDXW'($urandom % 6) : IDXW'($urandom);
      d = narrow ? IDXW'($urandom % 6) : IDXW'($urandom);
      issue(($urandom % 8) != 0, ($urandom % 2) == 0, ($urandom % 4) != 0, a,
            ($urandom % 3) != 0, b, ($urandom % 5) != 0, d, ($urandom % 5) == 0, "");
    end

    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    ref_vec = '0;
    compare("R1", 1'b0, 1'b0, '0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule